// File: doc/BRIEF.md
# Fine Phase Shift Controller

This block is the digital control side of a clock phase shifter. It holds a signed phase offset counted in 1/256ths of the input clock period. It also turns that offset into tap selections for a delay line. The analog delay line itself is not part of the block. A static mode parameter picks one of two behaviours:

- **Static mode.** The offset is loaded at reset and never changes afterwards.
- **Stepping mode.** A requester moves the offset one unit up or down per request. Every accepted request is confirmed by a one-cycle completion pulse.

Whatever the delay line can reach bounds the offset. That bound is worked out at elaboration from the clock period and the delay-line span. In stepping mode the zero point sits in the middle of the line, so only half the span is available in each direction. A request that would push the offset past the bound leaves it at the bound. The completion pulse is still given, so the requester never waits forever.

Requests are handled by a three-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | Waiting for a request |
| `ST_BUSY` | Counting out the step latency |
| `ST_DONE` | Completion pulse; the offset takes its new value on entry |

| Transition | Condition |
|---|---|
| IDLE→BUSY (accept) | A rising edge of the request input is seen while idle |
| BUSY→BUSY (count) | The latency counter has not reached its end |
| BUSY→DONE (commit) | The latency counter reaches its end |
| DONE→IDLE (release) | Always, after one cycle |

Top module: `fine_phase_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the offset is set to `INIT_OFFSET` clamped to ±limit, `step_done` goes low and any step in flight is dropped.
- R2: The limit is min(255, floor(256·LINE_SPAN/CLK_PERIOD)) in static mode and min(255, floor(128·LINE_SPAN/CLK_PERIOD)) in stepping mode.
- R3: In stepping mode an accepted request moves the offset by exactly one unit: up when `step_up` was 1 at the accepting edge, down when it was 0.
- R4: Take the edge at which a request is accepted as edge 0. The offset takes its new value at edge `STEP_LAT`, and `step_done` is high for exactly the one cycle that follows that edge.
- R5: A request is accepted only on a 0→1 change of `step_en` seen while idle. A rising edge seen while busy or done is ignored. An enable held high yields only one step.
- R6: A step that would pass ±limit leaves the offset at the limit, and `step_done` is still pulsed.
- R7: In stepping mode `in_tap` = NTAPS/2 + offset and `fb_tap` = NTAPS/2.
- R8: In static mode the offset never changes and `step_done` stays low. A non-negative offset gives `in_tap` = offset and `fb_tap` = 0. A negative offset gives `fb_tap` = −offset and `in_tap` = 0.
- R9: A reset raised while a step is in flight cancels that step. No completion pulse follows, and the offset reads the initial value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Step request; its rising edge starts one step |
| step_up | input | 1 | Direction of the step: 1 increments, 0 decrements |
| step_done | output | 1 | One-cycle pulse when a step has completed |
| phase_ofs | output | 9 | Signed phase offset in 1/256 period units |
| in_tap | output | $clog2(NTAPS) | Tap selection for the input-path delay |
| fb_tap | output | $clog2(NTAPS) | Tap selection for the feedback-path delay |

## Verification
Two functions can meet in one cycle: the commit of a step, and either saturation at the limit or a new rising edge of the request.

- **Saturation.** The offset is driven to +limit and to −limit, with further steps requested at the bound. At each pulse the scoreboard expects the clamped value and the exact pulse cycle.
- **Request while busy.** A second rising edge of `step_en` is produced while the block is counting out a step. An enable is also held high for many cycles.
- **Cancelled step.** A reset lands in the middle of a step.

In the last two cases the monitor flags any completion pulse that no queued expectation accounts for.

// File: rtl/fps_pkg.sv
package fps_pkg;

    localparam int OFS_W   = 9;
    localparam int OFS_MAX = 255;

    typedef logic signed [OFS_W-1:0] ofs_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } step_state_e;

    // Reachable offset bound for a given period and delay span.
    function automatic int reach_limit(input int period, input int span, input bit var_mode);
        longint num;
        longint quo;
        num = longint'(span) * (var_mode ? longint'(128) : longint'(256));
        quo = num / longint'(period);
        return (quo > longint'(OFS_MAX)) ? OFS_MAX : int'(quo);
    endfunction

    function automatic int clamp_to(input int value, input int lim);
        if (value > lim)  return lim;
        if (value < -lim) return -lim;
        return value;
    endfunction

endpackage

// File: rtl/fps_step_fsm.sv
module fps_step_fsm
    import fps_pkg::*;
#(
    parameter int STEP_LAT = 3,
    parameter bit VAR_MODE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic req_en,
    input  logic req_up,
    output logic commit,
    output logic commit_up,
    output logic step_done
);

    localparam int CNT_W = (STEP_LAT < 2) ? 1 : $clog2(STEP_LAT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_LAT - 1);

    step_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             up_q;
    logic             en_q;
    logic             accept;
    logic             cnt_end;

    assign cnt_end = (cnt_q == CNT_LAST);

    generate
        if (VAR_MODE) begin : g_stepping
            assign accept = req_en & ~en_q & (state_q == ST_IDLE);
        end else begin : g_static
            assign accept = 1'b0;
        end
    endgenerate

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_BUSY;
                    cnt_d   = '0;
                end
            end
            ST_BUSY: begin
                if (cnt_end) begin
                    state_d = ST_DONE;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            up_q    <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            en_q    <= req_en;
            if (accept) begin
                up_q <= req_up;
            end
        end
    end

    // outputs
    always_comb begin
        step_done = (state_q == ST_DONE);
        commit    = (state_q == ST_BUSY) && cnt_end;
        commit_up = up_q;
    end

endmodule

// File: rtl/fps_offset_reg.sv
module fps_offset_reg
    import fps_pkg::*;
#(
    parameter int LIMIT = 64,
    parameter int INIT  = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic commit_up,
    output ofs_t offset
);

    localparam ofs_t HI    = ofs_t'(LIMIT);
    localparam ofs_t LO    = ofs_t'(-LIMIT);
    localparam ofs_t START = ofs_t'(clamp_to(INIT, LIMIT));

    ofs_t offset_q, offset_d;

    always_comb begin
        offset_d = offset_q;
        if (commit) begin
            if (commit_up) begin
                offset_d = (offset_q >= HI) ? HI : offset_q + ofs_t'(1);
            end else begin
                offset_d = (offset_q <= LO) ? LO : offset_q - ofs_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q <= START;
        end else begin
            offset_q <= offset_d;
        end
    end

    assign offset = offset_q;

endmodule

// File: rtl/fps_tap_map.sv
module fps_tap_map
    import fps_pkg::*;
#(
    parameter int NTAPS    = 512,
    parameter bit VAR_MODE = 1'b1,
    localparam int TAP_W   = $clog2(NTAPS)
) (
    input  ofs_t             offset,
    output logic [TAP_W-1:0] in_tap,
    output logic [TAP_W-1:0] fb_tap
);

    localparam int MID = NTAPS / 2;

    generate
        if (VAR_MODE) begin : g_centred
            always_comb begin
                in_tap = TAP_W'(MID + int'(offset));
                fb_tap = TAP_W'(MID);
            end
        end else begin : g_steered
            always_comb begin
                if (offset < 0) begin
                    in_tap = '0;
                    fb_tap = TAP_W'(-int'(offset));
                end else begin
                    in_tap = TAP_W'(int'(offset));
                    fb_tap = '0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fine_phase_ctrl.sv
module fine_phase_ctrl
    import fps_pkg::*;
#(
    parameter int CLK_PERIOD  = 2000,
    parameter int LINE_SPAN   = 1000,
    parameter bit VAR_MODE    = 1'b1,
    parameter int INIT_OFFSET = 0,
    parameter int STEP_LAT    = 3,
    parameter int NTAPS       = 512,
    localparam int TAP_W      = $clog2(NTAPS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_en,
    input  logic                    step_up,
    output logic                    step_done,
    output logic signed [OFS_W-1:0] phase_ofs,
    output logic [TAP_W-1:0]        in_tap,
    output logic [TAP_W-1:0]        fb_tap
);

    localparam int LIMIT = reach_limit(CLK_PERIOD, LINE_SPAN, VAR_MODE);

    logic commit;
    logic commit_up;
    ofs_t offset;

    fps_step_fsm #(
        .STEP_LAT (STEP_LAT),
        .VAR_MODE (VAR_MODE)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_en    (step_en),
        .req_up    (step_up),
        .commit    (commit),
        .commit_up (commit_up),
        .step_done (step_done)
    );

    fps_offset_reg #(
        .LIMIT (LIMIT),
        .INIT  (INIT_OFFSET)
    ) u_ofs (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .commit_up (commit_up),
        .offset    (offset)
    );

    fps_tap_map #(
        .NTAPS    (NTAPS),
        .VAR_MODE (VAR_MODE)
    ) u_taps (
        .offset (offset),
        .in_tap (in_tap),
        .fb_tap (fb_tap)
    );

    assign phase_ofs = offset;

endmodule

// File: rtl/fine_phase_ctrl_chk.sv
module fine_phase_ctrl_chk
    import fps_pkg::*;
#(
    parameter bit VAR_MODE = 1'b1,
    parameter int LIMIT    = 64,
    parameter int TAP_W    = 9
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    step_done,
    input logic signed [OFS_W-1:0] phase_ofs,
    input logic [TAP_W-1:0]        in_tap,
    input logic [TAP_W-1:0]        fb_tap
);

    localparam ofs_t LIM_P = ofs_t'(LIMIT);
    localparam ofs_t LIM_N = ofs_t'(-LIMIT);

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        step_done |=> !step_done);

    a_r6_within_limit: assert property (@(posedge clk) disable iff (rst)
        (phase_ofs <= LIM_P) && (phase_ofs >= LIM_N));

    a_r4_move_with_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(phase_ofs) |-> step_done);

    a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
        step_done |-> ((phase_ofs == $past(phase_ofs)) ||
                       (phase_ofs == $past(phase_ofs) + ofs_t'(1)) ||
                       (phase_ofs == $past(phase_ofs) - ofs_t'(1))));

    generate
        if (VAR_MODE) begin : g_var_chk
            a_r7_tap_tracks: assert property (@(posedge clk) disable iff (rst)
                (int'(in_tap) - int'(fb_tap)) == int'(phase_ofs));
        end else begin : g_fix_chk
            a_r8_static_hold: assert property (@(posedge clk) disable iff (rst)
                !step_done && $stable(phase_ofs));
        end
    endgenerate

endmodule

bind fine_phase_ctrl fine_phase_ctrl_chk #(
    .VAR_MODE (VAR_MODE),
    .LIMIT    (LIMIT),
    .TAP_W    (TAP_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .step_done (step_done),
    .phase_ofs (phase_ofs),
    .in_tap    (in_tap),
    .fb_tap    (fb_tap)
);

// File: tb/fine_phase_ctrl_tb_top.sv
`timescale 1ns/1ps
module fine_phase_ctrl_tb_top;

    localparam int LAT    = 3;
    localparam int INIT_V = 60;
    localparam int LIM_V  = (128 * 1000) / 2000;   // stepping-mode bound: 64
    localparam int MID    = 256;

    typedef struct { int ofs; longint cyc; } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_en = 1'b0;
    logic step_up = 1'b0;
    logic step_done, fx_done, fp_done;
    logic signed [8:0] phase_ofs, fx_ofs, fp_ofs;
    logic [8:0] in_tap, fb_tap, fx_in, fx_fb, fp_in, fp_fb;

    int n_cmp = 0;
    int n_bad = 0;
    longint cyc = 0;
    int m_ofs = INIT_V;
    bit ended = 1'b0;
    bit done_prev = 1'b0;
    item_t exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fine_phase_ctrl #(.CLK_PERIOD(2000), .LINE_SPAN(1000), .VAR_MODE(1'b1),
                      .INIT_OFFSET(INIT_V), .STEP_LAT(LAT), .NTAPS(512)) dut_i (
        .clk(clk), .rst(rst), .step_en(step_en), .step_up(step_up),
        .step_done(step_done), .phase_ofs(phase_ofs), .in_tap(in_tap), .fb_tap(fb_tap));

    fine_phase_ctrl #(.CLK_PERIOD(1000), .LINE_SPAN(1000), .VAR_MODE(1'b0),
                      .INIT_OFFSET(-300), .STEP_LAT(LAT), .NTAPS(512)) dut_fx_i (
        .clk(clk), .rst(rst), .step_en(step_en), .step_up(step_up),
        .step_done(fx_done), .phase_ofs(fx_ofs), .in_tap(fx_in), .fb_tap(fx_fb));

    fine_phase_ctrl #(.CLK_PERIOD(2000), .LINE_SPAN(1000), .VAR_MODE(1'b0),
                      .INIT_OFFSET(200), .STEP_LAT(LAT), .NTAPS(512)) dut_fp_i (
        .clk(clk), .rst(rst), .step_en(step_en), .step_up(step_up),
        .step_done(fp_done), .phase_ofs(fp_ofs), .in_tap(fp_in), .fb_tap(fp_fb));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    // Monitor: pops one expectation per completion pulse
    always @(negedge clk) begin
        if (!rst && step_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 done with no accepted request", 1, 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(int'(phase_ofs) == it.ofs, "R3 offset at done", phase_ofs, it.ofs);
                chk(cyc == it.cyc, "R4 done cycle", cyc, it.cyc);
            end
        end
        if (!rst && done_prev && step_done)
            chk(1'b0, "R4 done longer than one cycle", 1, 0);
        if (!rst && (fx_done || fp_done))
            chk(1'b0, "R8 done in static mode", 1, 0);
        done_prev = step_done;
    end

    function automatic int model_step(input int v, input bit up);
        if (up)  return (v >= LIM_V) ? LIM_V : v + 1;
        return (v <= -LIM_V) ? -LIM_V : v - 1;
    endfunction

    // Driver: one clean request; expectation pushed at the accepting edge
    task automatic do_step(input bit up);
        @(negedge clk);
        step_en = 1'b1;
        step_up = up;
        @(negedge clk);
        m_ofs = model_step(m_ofs, up);
        exp_q.push_back('{m_ofs, cyc + LAT});
        step_en = 1'b0;
        repeat (LAT + 2) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 / R7 / R2 / R8 reset values
        chk(int'(phase_ofs) == INIT_V, "R1 reset offset", phase_ofs, INIT_V);
        chk(step_done == 1'b0, "R1 reset done", step_done, 0);
        chk(int'(in_tap) == MID + INIT_V, "R7 in_tap", in_tap, MID + INIT_V);
        chk(int'(fb_tap) == MID, "R7 fb_tap", fb_tap, MID);
        chk(int'(fx_ofs) == -255, "R2 static limit 255", fx_ofs, -255);
        chk(int'(fp_ofs) == 128, "R2 static limit 128", fp_ofs, 128);
        chk(fx_in == 9'd0 && int'(fx_fb) == 255, "R8 negative to feedback", fx_fb, 255);
        chk(int'(fp_in) == 128 && fp_fb == 9'd0, "R8 positive to input", fp_in, 128);
        rst = 1'b0;
        @(negedge clk);

        // R3 / R6 / R2: climb to and beyond the upper limit
        for (int i = 0; i < 6; i++) do_step(1'b1);
        chk(int'(phase_ofs) == LIM_V, "R6 upper saturation", phase_ofs, LIM_V);
        chk(int'(in_tap) == MID + LIM_V, "R7 in_tap at top", in_tap, MID + LIM_V);

        // R5: enable held high gives one step
        @(negedge clk);
        step_en = 1'b1; step_up = 1'b0;
        @(negedge clk);
        m_ofs = model_step(m_ofs, 1'b0);
        exp_q.push_back('{m_ofs, cyc + LAT});
        repeat (19) @(negedge clk);
        step_en = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        chk(int'(phase_ofs) == LIM_V - 1, "R5 held enable single step", phase_ofs, LIM_V - 1);

        // R5: second rising edge while busy is ignored
        step_en = 1'b1; step_up = 1'b0;
        @(negedge clk);
        m_ofs = model_step(m_ofs, 1'b0);
        exp_q.push_back('{m_ofs, cyc + LAT});
        step_en = 1'b0;
        @(negedge clk);
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        repeat (LAT + 4) @(negedge clk);
        chk(int'(phase_ofs) == LIM_V - 2, "R5 busy edge ignored", phase_ofs, LIM_V - 2);

        // R6: descend past the lower limit
        for (int i = 0; i < 132; i++) do_step(1'b0);
        chk(int'(phase_ofs) == -LIM_V, "R6 lower saturation", phase_ofs, -LIM_V);
        chk(int'(in_tap) == MID - LIM_V, "R7 in_tap at bottom", in_tap, MID - LIM_V);

        // R3: direction turns back up
        do_step(1'b1);
        chk(int'(phase_ofs) == -LIM_V + 1, "R3 increment from bottom", phase_ofs, -LIM_V + 1);

        // R9: reset during a step
        @(negedge clk);
        step_en = 1'b1; step_up = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_ofs = INIT_V;
        chk(int'(phase_ofs) == INIT_V, "R9 offset after abort", phase_ofs, INIT_V);
        chk(step_done == 1'b0, "R9 done after abort", step_done, 0);
        repeat (LAT + 4) @(negedge clk);
        chk(int'(phase_ofs) == INIT_V, "R9 no late commit", phase_ofs, INIT_V);

        // R8: static instances saw all the requests
        chk(int'(fx_ofs) == -255, "R8 static offset held", fx_ofs, -255);
        chk(int'(fp_ofs) == 128, "R8 static offset held", fp_ofs, 128);
        chk(exp_q.size() == 0, "R4 every request completed", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule